// File: doc/BRIEF.md
# Serial Receive Queue with Level Interrupt

This block buffers received serial characters between the line deserializer and the data-register read path of a serial port. Each stored word is 12 bits: an 8-bit character in bits 7:0 and a 4-bit error field in bits 11:8. The deserializer offers words through a push strobe, or a line-break strobe that stores a fixed break word. A read of the data register pops the oldest word, and at that moment the word's error field is latched into a status register. Software can later clear that register.

A configuration input picks the buffering mode. With buffering on, the queue holds up to 16 words. With buffering off, it acts as a one-word holding register. Any change of that input empties the queue and rewinds it to slot 0. The block drives empty, full and ready indications, the word at the head of the queue, and a receive-interrupt request. That request follows the queue's fill level against a trigger level.

A push that cannot be taken is discarded, and one cycle later a single-cycle overrun strobe goes to the interrupt logic.

Top module: `rxq_buffer`

## Requirements
- R1: After synchronous reset, empty_o is 1, full_o is 0, rdy_o is 1, rx_irq_o is 0, ovr_o is 0 and stat_o is 0.
- R2: Words leave in the order they were accepted. pop_word_o always shows the oldest stored word. The write slot is (read slot + fill count) modulo the depth, so storage wraps around after slot 15.
- R3: With fifo_en_i high, rdy_o is 1 while fewer than 16 words are stored. With fifo_en_i low, rdy_o is 1 only while the queue holds nothing.
- R4: An accepted push clears empty_o. It sets full_o when fifo_en_i is low or the fill count reaches 16. A pop clears full_o. empty_o sets when the fill count drops to zero. full_o and empty_o are never both 1.
- R5: A pop removes a word only when the queue holds one. A push and a pop in the same cycle on a non-empty queue leave the fill count unchanged.
- R6: A pop copies bits 11:8 of the popped word into stat_o. stat_clr_i zeroes stat_o. When both occur in the same cycle, the pop's capture wins.
- R7: brk_i stores the word 0x400: character zero, with only bit 2 of the error field (word bit 10) set. It takes priority over push_word_i.
- R8: rx_irq_o sets when an accepted push makes the fill count equal the trigger level (default 1). It clears when a pop leaves the fill count at the trigger level minus one.
- R9: A cycle in which fifo_en_i differs from its previous value empties the queue. The fill count and read slot return to zero, empty_o sets, full_o clears, and pop_word_o then shows slot 0. Pushes and pops in that cycle are ignored.
- R10: A push or break strobe that is not accepted stores nothing and makes ovr_o high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en_i | input | 1 | 1 = 16-deep buffering, 0 = single-word holding |
| push_i | input | 1 | Store push_word_i |
| push_word_i | input | 12 | Error field (11:8) and character (7:0) |
| brk_i | input | 1 | Store the line-break word 0x400 |
| pop_i | input | 1 | Remove the head word (data-register read) |
| stat_clr_i | input | 1 | Zero the captured status |
| rdy_o | output | 1 | A push would be accepted now |
| empty_o | output | 1 | Queue holds no word |
| full_o | output | 1 | Queue cannot take more words |
| pop_word_o | output | 12 | Word at the head of the queue |
| stat_o | output | 4 | Error field of the last popped word |
| rx_irq_o | output | 1 | Receive interrupt request |
| ovr_o | output | 1 | One-cycle strobe: a push was dropped |

## Verification
The hardest state to reach from the ports is a full queue whose read slot is not zero. Only there are the full, wrap-around and overrun behaviours seen together. The stimulus first moves the read slot forward with a short table-driven sequence. That sequence also covers single-word mode, a mode-change flush, a break word, and simultaneous push with pop. Directed code then fills all 16 slots so that the writes wrap, offers one more push, and drains the queue while checking the order of every word.

// File: rtl/rxq_pkg.sv
// Package: word layout shared by the receive queue modules.
// Assumes an 8-bit character with a 4-bit error field above it.
package rxq_pkg;
    localparam int RXQ_CHAR_W = 8;
    localparam int RXQ_ERR_W  = 4;
    localparam int RXQ_WORD_W = RXQ_CHAR_W + RXQ_ERR_W;
    localparam int RXQ_BRK_IDX = 2;   // position of break flag in the error field

    typedef struct packed {
        logic [RXQ_ERR_W-1:0]  err;
        logic [RXQ_CHAR_W-1:0] ch;
    } rxq_word_t;

    // Word stored for a line break: zero character, only the break flag set.
    function automatic rxq_word_t rxq_break_word();
        rxq_word_t w;
        w.ch  = '0;
        w.err = '0;
        w.err[RXQ_BRK_IDX] = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/rxq_mem.sv
// Module: rxq_mem
// Circular storage for the receive queue. It has one write port and a
// combinational read port. Assumes DEPTH is a power of two so that the
// slot indices wrap naturally. Storage is not reset.
module rxq_mem
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_slot,
    input  rxq_word_t        wr_word,
    input  logic [PTR_W-1:0] rd_slot,
    output rxq_word_t        rd_word
);
    rxq_word_t slots [DEPTH];

    // Write the accepted word into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_slot] <= wr_word;
        end
    end

    // Present the head word without delay.
    always_comb begin
        rd_word = slots[rd_slot];
    end
endmodule

// File: rtl/rxq_ctl.sv
// Module: rxq_ctl
// Fill count, read slot, ready/full/empty tracking and the flush on a
// mode change. Assumes DEPTH is a power of two. The mode input is
// compared with its previous value, and the reset value of that copy is 0.
module rxq_ctl #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en_i,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             accept,
    output logic             reject,
    output logic             pop_ok,
    output logic             flush,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [PTR_W-1:0] wr_slot,
    output logic [PTR_W-1:0] rd_slot,
    output logic             rdy,
    output logic             empty,
    output logic             full
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic             mode_q;
    logic [CNT_W-1:0] count;
    logic             pop_take;

    // Decide readiness, acceptance and the next fill count.
    always_comb begin
        flush    = (fifo_en_i != mode_q);
        rdy      = fifo_en_i ? (count < CNT_MAX) : (count == '0);
        accept   = push_req && rdy && !flush;
        reject   = push_req && !accept;
        pop_ok   = pop_req && !flush;
        pop_take = pop_ok && (count != '0);
        if (flush) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = count + CNT_W'(accept) - CNT_W'(pop_take);
        end
        wr_slot = rd_slot + count[PTR_W-1:0];
    end

    // Update mode copy, count and read slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            count   <= '0;
            rd_slot <= '0;
        end else begin
            mode_q <= fifo_en_i;
            count  <= cnt_nxt;
            if (flush) begin
                rd_slot <= '0;
            end else if (pop_take) begin
                rd_slot <= rd_slot + 1'b1;
            end
        end
    end

    // Maintain the full and empty flags on push, pop and flush events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty <= 1'b1;
            full  <= 1'b0;
        end else if (flush) begin
            empty <= 1'b1;
            full  <= 1'b0;
        end else begin
            if (accept && (!fifo_en_i || cnt_nxt == CNT_MAX)) begin
                full <= 1'b1;
            end else if (pop_ok) begin
                full <= 1'b0;
            end
            if (accept) begin
                empty <= 1'b0;
            end else if (pop_take && cnt_nxt == '0) begin
                empty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxq_side.sv
// Module: rxq_side
// Status capture on pop, the level interrupt against TRIG and the
// overrun strobe. Assumes 1 <= TRIG <= the queue depth.
module rxq_side
    import rxq_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int TRIG  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 reject,
    input  logic                 pop_ok,
    input  logic [CNT_W-1:0]     cnt_nxt,
    input  logic [RXQ_ERR_W-1:0] head_err,
    input  logic                 stat_clr,
    output logic [RXQ_ERR_W-1:0] stat,
    output logic                 irq,
    output logic                 ovr
);
    localparam logic [CNT_W-1:0] LVL_SET = CNT_W'(TRIG);
    localparam logic [CNT_W-1:0] LVL_CLR = CNT_W'(TRIG - 1);

    // Capture the popped error field, or clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else if (pop_ok) begin
            stat <= head_err;
        end else if (stat_clr) begin
            stat <= '0;
        end
    end

    // Raise or drop the interrupt on exact fill-level crossings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (accept && cnt_nxt == LVL_SET) begin
            irq <= 1'b1;
        end else if (pop_ok && cnt_nxt == LVL_CLR) begin
            irq <= 1'b0;
        end
    end

    // Pulse overrun one cycle after a dropped push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else begin
            ovr <= reject;
        end
    end
endmodule

// File: rtl/rxq_buffer.sv
// Module: rxq_buffer (top)
// Receive queue of a serial port: storage, control and side outputs.
// Assumes DEPTH is a power of two and that push, break and pop are
// single-cycle strobes from the deserializer and the register decoder.
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_en_i,
    input  logic                  push_i,
    input  logic [RXQ_WORD_W-1:0] push_word_i,
    input  logic                  brk_i,
    input  logic                  pop_i,
    input  logic                  stat_clr_i,
    output logic                  rdy_o,
    output logic                  empty_o,
    output logic                  full_o,
    output logic [RXQ_WORD_W-1:0] pop_word_o,
    output logic [RXQ_ERR_W-1:0]  stat_o,
    output logic                  rx_irq_o,
    output logic                  ovr_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push_req;
    rxq_word_t        in_word;
    rxq_word_t        head_word;
    logic             accept;
    logic             reject;
    logic             pop_ok;
    logic             flush;
    logic [CNT_W-1:0] cnt_nxt;
    logic [PTR_W-1:0] wr_slot;
    logic [PTR_W-1:0] rd_slot;

    // Merge the break strobe with ordinary pushes; break wins.
    always_comb begin
        push_req = push_i || brk_i;
        in_word  = brk_i ? rxq_break_word() : rxq_word_t'(push_word_i);
    end

    rxq_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (accept),
        .wr_slot (wr_slot),
        .wr_word (in_word),
        .rd_slot (rd_slot),
        .rd_word (head_word)
    );

    rxq_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en_i (fifo_en_i),
        .push_req  (push_req),
        .pop_req   (pop_i),
        .accept    (accept),
        .reject    (reject),
        .pop_ok    (pop_ok),
        .flush     (flush),
        .cnt_nxt   (cnt_nxt),
        .wr_slot   (wr_slot),
        .rd_slot   (rd_slot),
        .rdy       (rdy_o),
        .empty     (empty_o),
        .full      (full_o)
    );

    rxq_side #(.CNT_W(CNT_W), .TRIG(TRIG)) u_side (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .reject   (reject),
        .pop_ok   (pop_ok),
        .cnt_nxt  (cnt_nxt),
        .head_err (head_word.err),
        .stat_clr (stat_clr_i),
        .stat     (stat_o),
        .irq      (rx_irq_o),
        .ovr      (ovr_o)
    );

    // Drive the head word out.
    always_comb begin
        pop_word_o = head_word;
    end
endmodule

// File: rtl/rxq_buffer_chk.sv
// Module: rxq_buffer_chk
// Port-level properties of rxq_buffer, attached through bind.
module rxq_buffer_chk
    import rxq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fifo_en_i,
    input logic                  push_i,
    input logic [RXQ_WORD_W-1:0] push_word_i,
    input logic                  brk_i,
    input logic                  pop_i,
    input logic                  stat_clr_i,
    input logic                  rdy_o,
    input logic                  empty_o,
    input logic                  full_o,
    input logic [RXQ_WORD_W-1:0] pop_word_o,
    input logic [RXQ_ERR_W-1:0]  stat_o,
    input logic                  rx_irq_o,
    input logic                  ovr_o
);
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    a_r3_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> rdy_o);

    a_r3_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en_i && !empty_o) |-> !rdy_o);

    a_r6_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_i && !pop_i) |=> (stat_o == '0));

    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq_o) |-> $past(push_i || brk_i));

    a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_irq_o) |-> $past(pop_i));

    a_r10_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> $past(push_i || brk_i));
endmodule

bind rxq_buffer rxq_buffer_chk u_chk (.*);

// File: tb/rxq_buffer_tb.sv
module rxq_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en_i = 1'b0;
    logic        push_i = 1'b0;
    logic [11:0] push_word_i = '0;
    logic        brk_i = 1'b0;
    logic        pop_i = 1'b0;
    logic        stat_clr_i = 1'b0;
    logic        rdy_o, empty_o, full_o, rx_irq_o, ovr_o;
    logic [11:0] pop_word_o;
    logic [3:0]  stat_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rxq_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en_i), .push_i(push_i),
        .push_word_i(push_word_i), .brk_i(brk_i), .pop_i(pop_i),
        .stat_clr_i(stat_clr_i), .rdy_o(rdy_o), .empty_o(empty_o),
        .full_o(full_o), .pop_word_o(pop_word_o), .stat_o(stat_o),
        .rx_irq_o(rx_irq_o), .ovr_o(ovr_o)
    );

    typedef struct packed {
        logic        en, push, brk, pop, clr;
        logic [11:0] din;
        logic        x_empty, x_full, x_rdy, x_irq, x_ovr;
        logic [3:0]  x_stat;
        logic        chk_d;
        logic [11:0] x_dout;
    } vec_t;

    // Each row: inputs for one clock, then the outputs expected after it.
    localparam vec_t VECS [10] = '{
        '{1'b0,1'b1,1'b0,1'b0,1'b0,12'h041, 1'b0,1'b1,1'b0,1'b1,1'b0,4'h0,1'b1,12'h041},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,12'h042, 1'b0,1'b1,1'b0,1'b1,1'b1,4'h0,1'b1,12'h041},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,12'h000, 1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,12'h000},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,12'h000, 1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,12'h041},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,12'h1A5, 1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,1'b1,12'h1A5},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,1'b1,12'h1A5},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,12'h033, 1'b0,1'b0,1'b1,1'b1,1'b0,4'h1,1'b1,12'h400},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,12'h000, 1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,1'b1,12'h400},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,12'h000, 1'b0,1'b0,1'b1,1'b1,1'b0,4'h4,1'b1,12'h033},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,12'h000, 1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,12'h000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Hold inputs across one rising edge; return at the next falling edge.
    task automatic step(input logic en, input logic psh, input logic brk,
                        input logic pp, input logic clr, input logic [11:0] d);
        fifo_en_i = en; push_i = psh; brk_i = brk; pop_i = pp;
        stat_clr_i = clr; push_word_i = d;
        @(negedge clk);
        push_i = 1'b0; brk_i = 1'b0; pop_i = 1'b0; stat_clr_i = 1'b0;
    endtask

    task automatic reset_checks();
        chk("R1 empty", 16'(empty_o), 16'd1);
        chk("R1 full", 16'(full_o), 16'd0);
        chk("R1 rdy", 16'(rdy_o), 16'd1);
        chk("R1 irq", 16'(rx_irq_o), 16'd0);
        chk("R1 ovr", 16'(ovr_o), 16'd0);
        chk("R1 stat", 16'(stat_o), 16'd0);
    endtask

    initial begin
        #1_600_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();

        // Table: single-word mode (R3, R4, R10), flush (R9), break (R7),
        // push with pop (R5), status capture and clear (R6), interrupt (R8).
        for (int i = 0; i < 10; i++) begin
            step(VECS[i].en, VECS[i].push, VECS[i].brk, VECS[i].pop, VECS[i].clr, VECS[i].din);
            chk($sformatf("R4 empty row%0d", i), 16'(empty_o), 16'(VECS[i].x_empty));
            chk($sformatf("R4 full row%0d", i), 16'(full_o), 16'(VECS[i].x_full));
            chk($sformatf("R3 rdy row%0d", i), 16'(rdy_o), 16'(VECS[i].x_rdy));
            chk($sformatf("R8 irq row%0d", i), 16'(rx_irq_o), 16'(VECS[i].x_irq));
            chk($sformatf("R10 ovr row%0d", i), 16'(ovr_o), 16'(VECS[i].x_ovr));
            chk($sformatf("R6 stat row%0d", i), 16'(stat_o), 16'(VECS[i].x_stat));
            if (VECS[i].chk_d) begin
                chk($sformatf("R2 R7 R9 word row%0d", i), 16'(pop_word_o), 16'(VECS[i].x_dout));
            end
        end

        // R2 R3: fill all 16 slots starting from read slot 3, so writes wrap.
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'(8'hC0 + i));
        end
        chk("R4 full at 16", 16'(full_o), 16'd1);
        chk("R3 not ready at 16", 16'(rdy_o), 16'd0);
        chk("R8 irq held", 16'(rx_irq_o), 16'd1);
        chk("R2 head after fill", 16'(pop_word_o), 16'h0C0);

        // R10: one push too many is dropped and strobes overrun once.
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h0EE);
        chk("R10 ovr strobe", 16'(ovr_o), 16'd1);
        chk("R10 head unchanged", 16'(pop_word_o), 16'h0C0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
        chk("R10 ovr one cycle", 16'(ovr_o), 16'd0);

        // R4: one pop clears full.
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000);
        chk("R4 full cleared", 16'(full_o), 16'd0);
        chk("R3 ready again", 16'(rdy_o), 16'd1);

        // R2: drain and check order.
        for (int i = 1; i < 16; i++) begin
            chk($sformatf("R2 order %0d", i), 16'(pop_word_o), 16'(8'hC0 + i));
            step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000);
        end
        chk("R4 empty after drain", 16'(empty_o), 16'd1);
        chk("R8 irq cleared after drain", 16'(rx_irq_o), 16'd0);

        // R9: mode change with stored words empties the queue.
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h055);
        end
        chk("R4 not empty before flush", 16'(empty_o), 16'd0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
        chk("R9 empty after flush", 16'(empty_o), 16'd1);
        chk("R9 full after flush", 16'(full_o), 16'd0);
        chk("R9 ready after flush", 16'(rdy_o), 16'd1);

        // R1: reset in the middle of activity.
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h3AA);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule